// File: doc/BRIEF.md
# SPI Mode-0 Register Slave

This block lets an external SPI master (clock idle low, data captured on the rising edge) reach a small byte-wide register map inside a random-bit generator. It holds the writable configuration of the generator: a control byte, an entropy-path control nibble and a 3-bit measurement select. It also offers a free scratch byte for link checks and read-only windows onto a 24-bit frequency counter, the alarm flag and the current random byte. All configuration fields drive dedicated output pins into the rest of the chip.

Each transaction is two bytes long while chip select is held low. The first byte carries a write flag in its top bit and a 7-bit address below it. The second byte is the write data, or a dummy byte during which the slave shifts out the addressed register. The three SPI inputs are brought into the system clock domain through synchronisers. Edges are then detected on the system clock, so SCLK must run well below the system clock (about one eighth or slower).

Top module: `spi_regmap_slave`

## Requirements
- R1: After reset every writable register reads 0x00, every configuration output is 0, and `spi_miso` is 0.
- R2: Address 0x20 is a scratch byte: a written value (for example 0xA5) is returned unchanged by a later read.
- R3: A write to 0x13 stores a full byte that drives the outputs as follows: bit 0 `ro_bypass`, bit 1 `manual_tune`, bit 2 `alarm_mask`, bits 4:3 `out_sel`, bits 7:5 `cond_sel`. Reading 0x13 returns the stored byte.
- R4: A write to 0x21 stores only bits 3:0. These drive bit 0 `sync_pre_xor`, bit 1 `inject_en`, bit 2 `inject_val` and bit 3 `stream_en`. Bits 7:4 are ignored and read as 0.
- R5: Address 0x10 reads as {3'b000, `alarm_in`, 1'b0, sel[2:0]}. A write there changes only the sel field, which drives `meas_sel`.
- R6: Addresses 0x00, 0x01 and 0x02 read `freq_count` bits 7:0, 15:8 and 23:16 respectively, and address 0x11 reads `rand_byte`.
- R7: Reads of any address outside 0x00-0x02, 0x10, 0x11, 0x13, 0x20 and 0x21 return 0x00. Writes to such addresses, and to the read-only addresses, change no register.
- R8: If chip select rises before all 16 bits of a write frame have been clocked in, the write is discarded.
- R9: `spi_miso` updates only after SCLK falling edges and is 0 while chip select is high and during the first byte of a frame. During the second byte it presents the read value MSB first.
- R10: A frame whose first bit is 0 (a read) changes no register, whatever value the second byte carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_sclk | input | 1 | SPI clock, idle low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| freq_count | input | 24 | Frequency counter value to expose |
| alarm_in | input | 1 | Health alarm flag to expose |
| rand_byte | input | 8 | Latest random byte to expose |
| ro_bypass | output | 1 | Single-oscillator path select |
| manual_tune | output | 1 | Force manual tuning |
| alarm_mask | output | 1 | Suppress alarm toward the tuner |
| out_sel | output | 2 | Output multiplexer select |
| cond_sel | output | 3 | Conditioner select |
| sync_pre_xor | output | 1 | Synchronise each oscillator before combining |
| inject_en | output | 1 | Enable test-bit injection |
| inject_val | output | 1 | Value of the injected bit |
| stream_en | output | 1 | Enable serial byte streaming |
| meas_sel | output | 3 | Oscillator chosen for frequency measurement |

## Verification
The register path is driven with directed frames that place a distinct, non-symmetric byte on each field (0xB6 into control, 0xFF into the entropy and select registers). A swapped or truncated bit position then shows up as a wrong pin or a wrong read-back. A seeded random stream of read and write frames covers mapped, read-only and unmapped addresses while the status inputs change between frames. This separates decode errors, missing write masks and stale read snapshots. Frames cut short at several bit counts, and reads with nonzero dummy data, show whether an incomplete or read-flagged frame can still reach a register. The MISO line is also sampled throughout the address byte, which exposes a read value that is launched too early.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;

    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;
    localparam int CNT_W  = $clog2(DATA_W);
    localparam int ENT_W  = 4;
    localparam int SEL_W  = 3;
    localparam int FREQ_W = 3 * DATA_W;

    // addresses whose values the external master depends on
    localparam logic [ADDR_W-1:0] A_FREQ0 = 7'h00;
    localparam logic [ADDR_W-1:0] A_FREQ1 = 7'h01;
    localparam logic [ADDR_W-1:0] A_FREQ2 = 7'h02;
    localparam logic [ADDR_W-1:0] A_MEAS  = 7'h10;
    localparam logic [ADDR_W-1:0] A_RAND  = 7'h11;
    localparam logic [ADDR_W-1:0] A_CTRL  = 7'h13;
    localparam logic [ADDR_W-1:0] A_SCR   = 7'h20;
    localparam logic [ADDR_W-1:0] A_ENT   = 7'h21;

    typedef struct packed {
        logic [CNT_W-1:0]  bit_cnt;
        logic              in_data;
        logic [DATA_W-1:0] rx;
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] tx;
        logic              miso;
        logic              wr_stb;
        logic [DATA_W-1:0] wdata;
        logic              sclk_prev;
    } frame_t;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] scratch;
        logic [ENT_W-1:0]  ent;
        logic [SEL_W-1:0]  sel;
    } regs_t;

endpackage

// File: rtl/spi_rm_sync.sv
module spi_rm_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain_d;
        logic [STAGES-1:0] chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], din[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[g]}};
            end else begin
                chain_q <= chain_d;
            end
        end

        assign dout[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/spi_rm_frame.sv
module spi_rm_frame
    import spi_rm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sclk,
    input  logic              mosi,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              miso,
    output logic              sclk_fall
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    frame_t st_d;
    frame_t st_q;
    logic   sclk_rise;
    logic [DATA_W-1:0] rx_next;

    assign sclk_rise = sclk & ~st_q.sclk_prev;
    assign sclk_fall = ~sclk & st_q.sclk_prev;
    assign rx_next   = {st_q.rx[DATA_W-2:0], mosi};
    // address seen by the register file while the last address bit arrives
    assign rd_addr   = rx_next[ADDR_W-1:0];

    always_comb begin
        st_d           = st_q;
        st_d.wr_stb    = 1'b0;
        st_d.sclk_prev = sclk;

        if (!cs_act) begin
            st_d.bit_cnt = '0;
            st_d.in_data = 1'b0;
            st_d.is_wr   = 1'b0;
            st_d.miso    = 1'b0;
        end else begin
            if (sclk_rise) begin
                st_d.rx      = rx_next;
                st_d.bit_cnt = st_q.bit_cnt + 1'b1;
                if (st_q.bit_cnt == LAST_BIT) begin
                    if (!st_q.in_data) begin
                        st_d.is_wr   = rx_next[DATA_W-1];
                        st_d.addr    = rx_next[ADDR_W-1:0];
                        st_d.tx      = rd_data;
                        st_d.in_data = 1'b1;
                    end else begin
                        st_d.wr_stb  = st_q.is_wr;
                        st_d.wdata   = rx_next;
                        st_d.in_data = 1'b0;
                        st_d.is_wr   = 1'b0;
                    end
                end
            end
            if (sclk_fall) begin
                if (st_q.in_data) begin
                    st_d.miso = st_q.tx[DATA_W-1];
                    st_d.tx   = {st_q.tx[DATA_W-2:0], 1'b0};
                end else begin
                    st_d.miso = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_stb  = st_q.wr_stb;
    assign wr_addr = st_q.addr;
    assign wr_data = st_q.wdata;
    assign miso    = st_q.miso;

endmodule

// File: rtl/spi_rm_regs.sv
module spi_rm_regs
    import spi_rm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [FREQ_W-1:0] freq_count,
    input  logic              alarm_in,
    input  logic [DATA_W-1:0] rand_byte,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [ENT_W-1:0]  ent_o,
    output logic [SEL_W-1:0]  sel_o
);

    regs_t rg_d;
    regs_t rg_q;
    logic [DATA_W-1:0] meas_view;

    always_comb begin
        rg_d = rg_q;
        if (wr_stb) begin
            unique case (wr_addr)
                A_CTRL:  rg_d.ctrl    = wr_data;
                A_SCR:   rg_d.scratch = wr_data;
                A_ENT:   rg_d.ent     = wr_data[ENT_W-1:0];
                A_MEAS:  rg_d.sel     = wr_data[SEL_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        meas_view              = '0;
        meas_view[SEL_W-1:0]   = rg_q.sel;
        meas_view[SEL_W+1]     = alarm_in;
    end

    always_comb begin
        unique case (rd_addr)
            A_FREQ0: rd_data = freq_count[0*DATA_W +: DATA_W];
            A_FREQ1: rd_data = freq_count[1*DATA_W +: DATA_W];
            A_FREQ2: rd_data = freq_count[2*DATA_W +: DATA_W];
            A_MEAS:  rd_data = meas_view;
            A_RAND:  rd_data = rand_byte;
            A_CTRL:  rd_data = rg_q.ctrl;
            A_SCR:   rd_data = rg_q.scratch;
            A_ENT:   rd_data = DATA_W'(rg_q.ent);
            default: rd_data = '0;
        endcase
    end

    assign ctrl_o = rg_q.ctrl;
    assign ent_o  = rg_q.ent;
    assign sel_o  = rg_q.sel;

endmodule

// File: rtl/spi_regmap_slave.sv
module spi_regmap_slave
    import spi_rm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_csn,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [FREQ_W-1:0] freq_count,
    input  logic              alarm_in,
    input  logic [DATA_W-1:0] rand_byte,
    output logic              ro_bypass,
    output logic              manual_tune,
    output logic              alarm_mask,
    output logic [1:0]        out_sel,
    output logic [2:0]        cond_sel,
    output logic              sync_pre_xor,
    output logic              inject_en,
    output logic              inject_val,
    output logic              stream_en,
    output logic [SEL_W-1:0]  meas_sel
);

    logic [2:0]        pins_s;
    logic              cs_act;
    logic              sclk_fall;
    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] ctrl_w;
    logic [ENT_W-1:0]  ent_w;
    logic [SEL_W-1:0]  sel_w;

    spi_rm_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_mosi, spi_sclk, spi_csn}),
        .dout  (pins_s)
    );

    assign cs_act = ~pins_s[0];

    spi_rm_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sclk      (pins_s[1]),
        .mosi      (pins_s[2]),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .miso      (spi_miso),
        .sclk_fall (sclk_fall)
    );

    spi_rm_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .freq_count (freq_count),
        .alarm_in   (alarm_in),
        .rand_byte  (rand_byte),
        .ctrl_o     (ctrl_w),
        .ent_o      (ent_w),
        .sel_o      (sel_w)
    );

    assign ro_bypass    = ctrl_w[0];
    assign manual_tune  = ctrl_w[1];
    assign alarm_mask   = ctrl_w[2];
    assign out_sel      = ctrl_w[4:3];
    assign cond_sel     = ctrl_w[7:5];
    assign sync_pre_xor = ent_w[0];
    assign inject_en    = ent_w[1];
    assign inject_val   = ent_w[2];
    assign stream_en    = ent_w[3];
    assign meas_sel     = sel_w;

endmodule

// File: rtl/spi_regmap_slave_chk.sv
module spi_regmap_slave_chk
    import spi_rm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_act,
    input logic              sclk_fall,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              spi_miso,
    input logic [DATA_W-1:0] ctrl_v,
    input logic [ENT_W-1:0]  ent_v,
    input logic [SEL_W-1:0]  sel_v
);

    assert_miso_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !spi_miso);

    assert_miso_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_miso) |-> ($past(sclk_fall) || $past(!cs_act)));

    assert_write_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(cs_act));

    assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && wr_addr == A_CTRL) |=> $stable(ctrl_v));

    assert_ent_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && wr_addr == A_ENT) |=> $stable(ent_v));

    assert_sel_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && wr_addr == A_MEAS) |=> $stable(sel_v));

endmodule

bind spi_regmap_slave spi_regmap_slave_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act    (cs_act),
    .sclk_fall (sclk_fall),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .spi_miso  (spi_miso),
    .ctrl_v    (ctrl_w),
    .ent_v     (ent_w),
    .sel_v     (sel_w)
);

// File: tb/spi_regmap_slave_tb_top.sv
module spi_regmap_slave_tb_top;

    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csn = 1'b1;
    logic        sclk = 1'b0;
    logic        mosi = 1'b0;
    logic        miso;
    logic [23:0] freq = 24'h0;
    logic        alarm = 1'b0;
    logic [7:0]  rnd = 8'h0;
    logic        ro_bypass, manual_tune, alarm_mask;
    logic [1:0]  out_sel;
    logic [2:0]  cond_sel;
    logic        sync_pre_xor, inject_en, inject_val, stream_en;
    logic [2:0]  meas_sel;

    int checks = 0;
    int fails  = 0;

    logic [7:0] m_ctrl = 8'h0;
    logic [7:0] m_scr  = 8'h0;
    logic [3:0] m_ent  = 4'h0;
    logic [2:0] m_sel  = 3'h0;

    always #10 clk = ~clk;

    spi_regmap_slave dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .spi_csn      (csn),
        .spi_sclk     (sclk),
        .spi_mosi     (mosi),
        .spi_miso     (miso),
        .freq_count   (freq),
        .alarm_in     (alarm),
        .rand_byte    (rnd),
        .ro_bypass    (ro_bypass),
        .manual_tune  (manual_tune),
        .alarm_mask   (alarm_mask),
        .out_sel      (out_sel),
        .cond_sel     (cond_sel),
        .sync_pre_xor (sync_pre_xor),
        .inject_en    (inject_en),
        .inject_val   (inject_val),
        .stream_en    (stream_en),
        .meas_sel     (meas_sel)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [6:0] a);
        case (a)
            7'h00:   return freq[7:0];
            7'h01:   return freq[15:8];
            7'h02:   return freq[23:16];
            7'h10:   return {3'b000, alarm, 1'b0, m_sel};
            7'h11:   return rnd;
            7'h13:   return m_ctrl;
            7'h20:   return m_scr;
            7'h21:   return {4'h0, m_ent};
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_write(input logic [6:0] a, input logic [7:0] d);
        case (a)
            7'h13: m_ctrl = d;
            7'h20: m_scr  = d;
            7'h21: m_ent  = d[3:0];
            7'h10: m_sel  = d[2:0];
            default: ;
        endcase
    endtask

    task automatic check_pins(input string tag);
        chk({tag, " ctrl pins"}, {cond_sel, out_sel, alarm_mask, manual_tune, ro_bypass}, m_ctrl);
        chk({tag, " entropy pins"}, {stream_en, inject_val, inject_en, sync_pre_xor}, m_ent);
        chk({tag, " meas_sel"}, meas_sel, m_sel);
    endtask

    // nbits < 16 raises chip select early
    task automatic xfer(input logic [7:0] b0, input logic [7:0] b1, input int nbits,
                        output logic [7:0] rdat, output logic quiet);
        rdat  = 8'h0;
        quiet = 1'b1;
        @(negedge clk) csn = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            if (i == nbits) break;
            mosi = (i < 8) ? b0[7-i] : b1[15-i];
            repeat (HALF) @(negedge clk);
            if (i < 8) begin
                if (miso !== 1'b0) quiet = 1'b0;
            end else begin
                rdat = {rdat[6:0], miso};
            end
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        csn = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d);
        logic [7:0] r;
        logic q;
        xfer({1'b1, a}, d, 16, r, q);
        model_write(a, d);
    endtask

    task automatic do_read(input string tag, input logic [6:0] a, input logic [7:0] dummy);
        logic [7:0] r;
        logic [7:0] e;
        logic q;
        e = exp_rd(a);
        xfer({1'b0, a}, dummy, 16, r, q);
        chk(tag, r, e);
        chk({tag, " R9 miso quiet in address byte"}, q, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic q;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        chk("R1 miso in reset", miso, 1'b0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_pins("R1 reset");
        chk("R1 miso after reset", miso, 1'b0);
        do_read("R1 scratch reset", 7'h20, 8'h00);
        do_read("R1 ctrl reset", 7'h13, 8'h00);

        do_write(7'h20, 8'hA5);
        do_read("R2 scratch A5", 7'h20, 8'h00);

        do_write(7'h13, 8'hB6);
        check_pins("R3 ctrl B6");
        do_read("R3 ctrl readback", 7'h13, 8'h00);

        do_write(7'h21, 8'hFF);
        check_pins("R4 entropy FF");
        do_read("R4 reserved bits read 0", 7'h21, 8'h00);
        do_write(7'h21, 8'h0A);
        check_pins("R4 entropy 0A");

        do_write(7'h10, 8'hFF);
        check_pins("R5 select masked");
        alarm = 1'b1;
        do_read("R5 status with alarm", 7'h10, 8'h00);
        alarm = 1'b0;
        do_read("R5 status no alarm", 7'h10, 8'h00);

        freq = 24'hABCDEF;
        rnd  = 8'h3C;
        do_read("R6 freq byte0", 7'h00, 8'h00);
        do_read("R6 freq byte1", 7'h01, 8'h00);
        do_read("R6 freq byte2", 7'h02, 8'h00);
        do_read("R6 random byte", 7'h11, 8'h00);

        do_read("R7 unmapped 7F", 7'h7F, 8'h00);
        do_read("R7 unmapped 12", 7'h12, 8'h00);
        do_write(7'h11, 8'h55);
        do_write(7'h00, 8'h55);
        do_write(7'h45, 8'h55);
        check_pins("R7 ignored writes");
        do_read("R7 rand after write", 7'h11, 8'h00);
        do_read("R7 scratch untouched", 7'h20, 8'h00);

        for (int k = 1; k < 16; k += 5) begin
            xfer({1'b1, 7'h20}, 8'h11, k + 1, r, q);
            xfer({1'b1, 7'h13}, 8'h11, k + 1, r, q);
        end
        do_read("R8 aborted scratch write", 7'h20, 8'h00);
        check_pins("R8 aborted ctrl write");

        xfer({1'b0, 7'h20}, 8'hFF, 16, r, q);
        xfer({1'b0, 7'h13}, 8'h00, 16, r, q);
        do_read("R10 read frame no write", 7'h20, 8'h00);
        check_pins("R10 pins after reads");

        do_write(7'h20, 8'h80);
        do_read("R9 msb first 80", 7'h20, 8'h00);
        do_write(7'h20, 8'h01);
        do_read("R9 lsb last 01", 7'h20, 8'hFF);

        for (int n = 0; n < 120; n++) begin
            logic [6:0] a;
            logic [7:0] d;
            case ($urandom % 9)
                0: a = 7'h00;
                1: a = 7'h01;
                2: a = 7'h02;
                3: a = 7'h10;
                4: a = 7'h11;
                5: a = 7'h13;
                6: a = 7'h20;
                7: a = 7'h21;
                default: a = 7'($urandom);
            endcase
            d     = 8'($urandom);
            freq  = 24'($urandom);
            alarm = 1'($urandom);
            rnd   = 8'($urandom);
            if ($urandom % 2 == 0) begin
                do_write(a, d);
                check_pins("R3 R4 R5 R7 random write");
            end else begin
                do_read("R2 R6 R7 random read", a, d);
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule